// File: doc/BRIEF.md
# Clocked serial I/O master

This block is a three-wire synchronous serial master. It has a serial clock output, a data output and a data input. A transmit holding register, a receive register and one shift register move 8-bit words, most significant bit first. The serial clock comes from the system clock through a divide-by-2N prescaler, so each half period of the serial clock lasts N system clocks. Two control inputs set the idle level of the clock and the phase of the data relative to the clock edges.

The block has two transfer modes. In single mode, a write to the transmit register while the port is idle starts one transfer, and writes made during that transfer are dropped. In continuous mode, the write fills the holding register, and the block moves that register into the shift register as soon as the line is free. If software refills the holding register before the current word ends, the next word follows with no gap. Transmit and receive can each be enabled on their own. A busy output and two one-cycle interrupt pulses report progress. Dropping the enable input aborts everything at once.

Top module: `sio_master`

## Requirements
- R1: Each transfer shifts 8 bits out on `sdo`, bit 7 first and bit 0 last. The same transfer samples 8 bits from `sdi`, and the first bit received becomes bit 7 of the received word.
- R2: Each half period of `sck` lasts N system clocks, where N is the value on `div` and a value of 0 acts as 1. One word therefore keeps `busy` high for 16·N clock cycles.
- R3: While no transfer is running, `sck` rests at the level on `cpol`. A word makes 16 transitions on `sck` and leaves it back at that level.
- R4: With `dphase`=1, bit 7 is on `sdo` from the cycle after the transfer starts, half a period before the first `sck` edge. `sdi` is sampled on the odd edges (1st, 3rd, …) and `sdo` changes on the even edges. With `dphase`=0, `sdo` changes on the odd edges and `sdi` is sampled on the even edges.
- R5: In single mode (`cont_mode`=0), a `wr` pulse while enabled and idle starts a transfer of `wdata`, and `busy` rises on the next clock edge.
- R6: In single mode, a `wr` while `busy` is 1 is discarded. The running transfer is not disturbed and no second word follows.
- R7: In continuous mode (`cont_mode`=1), a `wr` fills the holding register. The register is moved into the shift register when the port is idle, or on the last edge of the current word, so `busy` stays high across consecutive words with no gap.
- R8: `irq_tx` is a one-cycle pulse raised each time the holding register is moved into the shift register, in continuous mode with transmit enabled. It is never raised in single mode or with `tx_en`=0.
- R9: With `rx_en`=1, `irq_rx` pulses for one cycle at the end of each word. `rxd` holds the received word in that same cycle.
- R10: With `rx_en`=0, `rxd` is not updated. In single mode `irq_rx` still pulses at the end of each word. In continuous mode it does not pulse.
- R11: With `tx_en`=0 (receive only), `sdo` is held at 0 throughout the transfer.
- R12: With `en`=0, any transfer is aborted. `busy` is 0 on the next clock, `sck` returns to the `cpol` level, no interrupt is raised for the aborted word, and writes are ignored.
- R13: After reset, `busy`, `irq_tx`, `irq_rx`, `sdo` and `rxd` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; low aborts and idles the port |
| cont_mode | input | 1 | 1 = continuous mode, 0 = single mode |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| cpol | input | 1 | Idle level of the serial clock |
| dphase | input | 1 | Data phase select |
| div | input | DIV_W | Half-period length N in system clocks |
| wr | input | 1 | Write strobe for the transmit register |
| wdata | input | DATA_W | Data for the transmit register |
| rxd | output | DATA_W | Receive register |
| busy | output | 1 | Transfer in progress |
| irq_tx | output | 1 | Transmit interrupt pulse |
| irq_rx | output | 1 | Receive interrupt pulse |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The hardest case to reach is the continuous-mode refill that arrives after a word has started but before its last edge. The stimulus issues two writes on nearby cycles, so the second one lands while the first word is shifting. It then checks that `busy` has exactly one falling edge over 32·N busy cycles and that two `irq_tx` pulses appear. A single-mode write placed a few cycles into a word checks the discard rule. The same write placed during an aborted transfer checks that nothing survives the disable. Looped-back and inverted-loopback data on `sdi`, captured on the sample edges, exercise both data phases and both clock levels.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef struct packed {
    logic cont;
    logic tx_en;
    logic rx_en;
    logic cpol;
    logic dphase;
  } sio_cfg_t;

endpackage

// File: rtl/sio_prescaler.sv
module sio_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cnt_n;
  logic [DIV_W-1:0] last;

  always_comb begin
    last  = (div == '0) ? '0 : div - DIV_W'(1);
    tick  = run & (cnt == last);
    cnt_n = (!run || tick) ? '0 : cnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

endmodule

// File: rtl/sio_seq.sv
module sio_seq
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  sio_cfg_t          cfg,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic              active,
  output logic              sck,
  output logic              load,
  output logic [DATA_W-1:0] load_data,
  output logic              sample,
  output logic              launch,
  output logic              capture,
  output logic              irq_tx,
  output logic              irq_rx
);

  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  logic [EW-1:0]     ecnt, ecnt_n;
  logic [DATA_W-1:0] txbuf, txbuf_n;
  logic              txfull, txfull_n;
  logic              active_n, sck_n, irq_tx_n, irq_rx_n;
  logic              step, odd_edge, last_edge, done;
  logic              start_single, take_buf, wr_ok;

  always_comb begin
    step         = en & active & tick;
    odd_edge     = ~ecnt[0];
    last_edge    = (ecnt == EW'(EDGES - 1));
    done         = step & last_edge;
    sample       = step & (cfg.dphase ? odd_edge : ~odd_edge);
    launch       = step & (cfg.dphase ? (~odd_edge & ~last_edge) : odd_edge);
    start_single = en & ~cfg.cont & wr & ~active;
    take_buf     = en & cfg.cont & txfull & (~active | done);
    load         = start_single | take_buf;
    load_data    = start_single ? wdata : txbuf;
    wr_ok        = en & wr & (cfg.cont | ~active);
    txbuf_n      = wr_ok ? wdata : txbuf;
    txfull_n     = en & cfg.cont & ((txfull & ~take_buf) | wr);
    active_n     = en & (load | (active & ~done));
    if (!active || load) ecnt_n = '0;
    else if (step)       ecnt_n = ecnt + EW'(1);
    else                 ecnt_n = ecnt;
    if (!en || !active)  sck_n = cfg.cpol;
    else if (step)       sck_n = ~sck;
    else                 sck_n = sck;
    irq_tx_n     = take_buf & cfg.tx_en;
    irq_rx_n     = done & (cfg.rx_en | ~cfg.cont);
    capture      = done & cfg.rx_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt   <= '0;
      txbuf  <= '0;
      txfull <= 1'b0;
      active <= 1'b0;
      sck    <= 1'b0;
      irq_tx <= 1'b0;
      irq_rx <= 1'b0;
    end else begin
      ecnt   <= ecnt_n;
      txbuf  <= txbuf_n;
      txfull <= txfull_n;
      active <= active_n;
      sck    <= sck_n;
      irq_tx <= irq_tx_n;
      irq_rx <= irq_rx_n;
    end
  end

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sample,
  input  logic              launch,
  input  logic              capture,
  input  logic              dphase,
  input  logic              tx_en,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rxd
);

  logic [DATA_W-1:0] shreg, shreg_n, shreg_smp, rxd_n;
  logic              sdo_q, sdo_n;

  always_comb begin
    shreg_smp = {shreg[DATA_W-2:0], sdi};
    if (load)        shreg_n = load_data;
    else if (sample) shreg_n = shreg_smp;
    else             shreg_n = shreg;
    if (load && dphase) sdo_n = load_data[DATA_W-1];
    else if (launch)    sdo_n = shreg[DATA_W-1];
    else                sdo_n = sdo_q;
    if (capture) rxd_n = sample ? shreg_smp : shreg;
    else         rxd_n = rxd;
    sdo = tx_en & sdo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      sdo_q <= 1'b0;
      rxd   <= '0;
    end else begin
      shreg <= shreg_n;
      sdo_q <= sdo_n;
      rxd   <= rxd_n;
    end
  end

endmodule

// File: rtl/sio_master.sv
module sio_master
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cont_mode,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              cpol,
  input  logic              dphase,
  input  logic [DIV_W-1:0]  div,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rxd,
  output logic              busy,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              sck,
  output logic              sdo,
  input  logic              sdi
);

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  sio_cfg_t          cfg;
  logic              tick, active, load, sample, launch, capture;
  logic [DATA_W-1:0] load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  always_comb begin
    rst_core_n = rst_pipe[1];
    cfg        = '{cont: cont_mode, tx_en: tx_en, rx_en: rx_en,
                   cpol: cpol, dphase: dphase};
    busy       = active;
  end

  sio_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (active),
    .div   (div),
    .tick  (tick)
  );

  sio_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .en        (en),
    .cfg       (cfg),
    .wr        (wr),
    .wdata     (wdata),
    .tick      (tick),
    .active    (active),
    .sck       (sck),
    .load      (load),
    .load_data (load_data),
    .sample    (sample),
    .launch    (launch),
    .capture   (capture),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx)
  );

  sio_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (load),
    .load_data (load_data),
    .sample    (sample),
    .launch    (launch),
    .capture   (capture),
    .dphase    (dphase),
    .tx_en     (tx_en),
    .sdi       (sdi),
    .sdo       (sdo),
    .rxd       (rxd)
  );

endmodule

// File: rtl/sio_master_chk.sv
module sio_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              cont_mode,
  input logic              tx_en,
  input logic              rx_en,
  input logic              cpol,
  input logic              busy,
  input logic              irq_tx,
  input logic              irq_rx,
  input logic              sck,
  input logic [DATA_W-1:0] rxd
);

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !busy && !$past(busy) && $stable(cpol)) |-> (sck == cpol)); // R3

  AST_TX_PULSE_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> ($past(cont_mode) && $past(tx_en))); // R8

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !irq_tx && !irq_rx)); // R12

  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |=> !irq_rx); // R9

  AST_RX_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> $past(busy)); // R9

  AST_RXD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx && !$past(rx_en)) |-> $stable(rxd)); // R10

endmodule

bind sio_master sio_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .en        (en),
  .cont_mode (cont_mode),
  .tx_en     (tx_en),
  .rx_en     (rx_en),
  .cpol      (cpol),
  .busy      (busy),
  .irq_tx    (irq_tx),
  .irq_rx    (irq_rx),
  .sck       (sck),
  .rxd       (rxd)
);

// File: tb/tb_sio_master.sv
module tb_sio_master;
  localparam int W  = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0, cont_mode = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
  logic          cpol = 1'b0, dphase = 1'b0, wr = 1'b0;
  logic [DW-1:0] div = 8'd1;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rxd;
  logic          busy, irq_tx, irq_rx, sck, sdo, sdi;
  int            sdi_mode = 0;

  assign sdi = (sdi_mode == 0) ? sdo : (sdi_mode == 1) ? ~sdo : 1'b1;

  always #2 clk = ~clk;

  sio_master #(.DATA_W(W), .DIV_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cont_mode(cont_mode), .tx_en(tx_en),
    .rx_en(rx_en), .cpol(cpol), .dphase(dphase), .div(div), .wr(wr),
    .wdata(wdata), .rxd(rxd), .busy(busy), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .sck(sck), .sdo(sdo), .sdi(sdi)
  );

  typedef struct {
    logic [W-1:0] rx;
    logic [W-1:0] out;
  } exp_t;

  exp_t         exp_q[$];
  exp_t         e;
  int           checks = 0, errors = 0, mchecks = 0, merrors = 0;
  int           busy_cyc = 0, busy_falls = 0, ntx = 0, nrx = 0;
  logic         prev_busy = 1'b0;
  logic [W-1:0] cap = '0;

  // captures sdo on every sampling edge of sck (R4)
  always @(sck) begin
    if (rst_n && ((sck != cpol) == dphase)) cap = {cap[W-2:0], sdo};
  end

  // monitor: pops the scoreboard on each receive pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cyc++;
      if (prev_busy && !busy) busy_falls++;
      prev_busy = busy;
      if (irq_tx) ntx++;
      if (irq_rx) begin
        nrx++;
        if (exp_q.size() == 0) begin
          mchecks++; merrors++;
          $display("FAIL R9: unexpected receive pulse, actual rxd %02h expected no pulse", rxd);
        end else begin
          e = exp_q.pop_front();
          mchecks += 2;
          if (rxd !== e.rx) begin
            merrors++;
            $display("FAIL R9/R10: rxd actual %02h expected %02h", rxd, e.rx);
          end
          if (cap !== e.out) begin
            merrors++;
            $display("FAIL R1/R4/R11: sdo word actual %02h expected %02h", cap, e.out);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual hung run expected completion");
    $display("CHECKS %0d ERRORS %0d", checks + mchecks + 1, errors + merrors + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic setup(input bit c, input bit t, input bit r, input bit p,
                       input bit d, input int n, input int sm);
    @(negedge clk);
    cont_mode = c; tx_en = t; rx_en = r; cpol = p; dphase = d;
    div = DW'(n); sdi_mode = sm;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [W-1:0] b);
    @(negedge clk);
    wr = 1'b1; wdata = b;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic push(input logic [W-1:0] r, input logic [W-1:0] o);
    exp_q.push_back('{rx: r, out: o});
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  int b0, f0, t0, r0;

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && irq_tx == 0 && irq_rx == 0, "R13", "reset busy/irq", {busy, irq_tx, irq_rx}, 0);
    chk(rxd == 0 && sdo == 0, "R13", "reset rxd/sdo", {rxd, sdo}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b1;

    // T1: single, loopback, cpol 0, dphase 0, N=2
    setup(0, 1, 1, 0, 0, 2, 0);
    b0 = busy_cyc;
    push(8'hA5, 8'hA5);
    wr_byte(8'hA5);
    chk(busy == 1, "R5", "busy after write", busy, 1);
    settle();
    chk(busy_cyc - b0 == 32, "R2", "busy cycles N=2", busy_cyc - b0, 32);

    // T2: single, inverted loopback, cpol 1, dphase 1, N=3
    setup(0, 1, 1, 1, 1, 3, 1);
    chk(sck == 1, "R3", "idle sck at cpol 1", sck, 1);
    push(8'h3C, 8'hC3);
    wr_byte(8'hC3);
    chk(sdo == 1 && sck == 1, "R4", "bit 7 on sdo before first edge", {sdo, sck}, 3);
    settle();
    chk(sck == 1, "R3", "sck back at idle level", sck, 1);

    // T3: single-mode write while busy is discarded
    setup(0, 1, 1, 0, 1, 2, 0);
    b0 = busy_cyc; f0 = busy_falls; r0 = nrx;
    push(8'h81, 8'h81);
    wr_byte(8'h81);
    repeat (3) @(negedge clk);
    wr_byte(8'h7E);
    settle();
    chk(busy_cyc - b0 == 32, "R6", "busy cycles with dropped write", busy_cyc - b0, 32);
    chk(nrx - r0 == 1 && busy_falls - f0 == 1, "R6", "words sent", nrx - r0, 1);

    // T4: single transmit-only: receive pulse, rxd unchanged
    setup(0, 1, 0, 0, 0, 2, 2);
    t0 = ntx; r0 = nrx;
    push(8'h81, 8'h55);
    wr_byte(8'h55);
    settle();
    chk(nrx - r0 == 1, "R10", "single tx-only receive pulses", nrx - r0, 1);
    chk(ntx == t0, "R8", "no transmit pulse in single mode", ntx - t0, 0);

    // T5: single receive-only: sdo low, all ones in
    setup(0, 0, 1, 0, 1, 2, 2);
    push(8'hFF, 8'h00);
    wr_byte(8'h99);
    repeat (10) @(negedge clk);
    chk(sdo == 0 && busy == 1, "R11", "sdo low during rx-only transfer", {sdo, busy}, 1);
    settle();

    // T6: continuous back-to-back, N=1
    setup(1, 1, 1, 0, 1, 1, 0);
    b0 = busy_cyc; f0 = busy_falls; t0 = ntx;
    push(8'h11, 8'h11);
    push(8'h22, 8'h22);
    wr_byte(8'h11);
    wr_byte(8'h22);
    settle();
    chk(busy_cyc - b0 == 32, "R7", "busy cycles for two words", busy_cyc - b0, 32);
    chk(busy_falls - f0 == 1, "R7", "busy gaps between words", busy_falls - f0, 1);
    chk(ntx - t0 == 2, "R8", "transmit pulses in continuous mode", ntx - t0, 2);

    // T7: continuous receive-only: no transmit pulse
    setup(1, 0, 1, 1, 0, 2, 2);
    t0 = ntx;
    push(8'hFF, 8'h00);
    wr_byte(8'h40);
    settle();
    chk(ntx == t0, "R8", "no transmit pulse with tx disabled", ntx - t0, 0);

    // T8: continuous transmit-only: no receive pulse
    setup(1, 1, 0, 0, 0, 2, 0);
    t0 = ntx; r0 = nrx;
    wr_byte(8'h6A);
    settle();
    chk(nrx == r0, "R10", "no receive pulse in continuous tx-only", nrx - r0, 0);
    chk(ntx - t0 == 1 && rxd == 8'hFF, "R10", "tx pulse and held rxd", rxd, 8'hFF);

    // T9: abort by disable
    setup(0, 1, 1, 0, 0, 2, 0);
    t0 = ntx; r0 = nrx;
    wr_byte(8'hF0);
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(busy == 0 && sck == 0, "R12", "abort busy/sck", {busy, sck}, 0);
    repeat (50) @(negedge clk);
    chk(nrx == r0 && ntx == t0, "R12", "pulses after abort", nrx - r0, 0);
    wr_byte(8'h12);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R12", "write while disabled", busy, 0);
    en = 1'b1;

    // T10: div of 0 behaves as 1
    setup(0, 1, 1, 1, 0, 0, 1);
    b0 = busy_cyc;
    push(8'hA5, 8'h5A);
    wr_byte(8'h5A);
    settle();
    chk(busy_cyc - b0 == 16, "R2", "busy cycles N=0", busy_cyc - b0, 16);

    chk(exp_q.size() == 0, "R9", "outstanding expected words", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrors);
    $finish;
  end

endmodule